// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state changes a processor core makes at the moment it enters an exception or interrupt handler. Each accept strobe from the core supplies the current status word, program counter, vector base and stack register, together with any pending exception code and any pending interrupt request. The block decides which event wins and whether the status word's block bit masks it. On the same clock edge it saves the old context into shadow outputs, forms the new status word, records the event code and computes the handler address.

An interrupt needs a vector from an external interrupt controller. The block hands the controller the current interrupt mask and uses whatever vector comes back in the same cycle. If no vector comes back, entry is abandoned and no state changes. A one-cycle done pulse follows every entry that goes ahead. Two further one-cycle pulses follow it: one tells the core to leave its sleep state, and one tells it to drop its delay-slot flags.

Top module: `exc_entry_seq`

## Requirements
- R1: A pending exception (`exc_valid`=1) always wins over an interrupt request. When both are present, only `exc_event` is written and `int_event` keeps its value.
- R2: When status bit 28 (block bit) of `sr_in` is set, any exception code other than 0x1E0 is replaced by code 0x000 and handled as that code. For example, 0x160 then gets no +2 adjustment. Code 0x1E0 passes through unchanged.
- R3: When the block bit is set, an interrupt request with `sleep_in`=0 is ignored: no done pulse and no output changes. With `sleep_in`=1 it proceeds. Every entry that goes ahead raises `sleep_clr` for one cycle.
- R4: `imask` always equals `sr_in[7:4]`. An interrupt accepted with `ic_vec_valid`=0 is abandoned: no done pulse and no output changes.
- R5: On entry, `saved_sr`, `saved_pc` and `saved_r15` take `sr_in`, the adjusted PC and `r15_in`. `sr_out` is `sr_in` with bits 30 (privileged), 29 (bank) and 28 (block) set.
- R6: With `ds_in`=1 the saved PC is `pc_in`-2 and `ds_clr` pulses for one cycle with done. With `ds_in`=0, `ds_clr` stays low.
- R7: Exception codes 0x000, 0x020 and 0x140 clear `sr_out` bit 15 (FPU disable), set `sr_out[7:4]` to 0xF and give `pc_out`=0xA0000000.
- R8: Codes 0x040 and 0x060 give `pc_out`=`vbr_in`+0x400. Every other exception code gives `vbr_in`+0x100. The code that was handled is stored in `exc_event`.
- R9: Code 0x160 adds 2 to the saved PC, on top of any delay-slot adjustment.
- R10: An accepted interrupt stores `ic_vec` in `int_event` and gives `pc_out`=`vbr_in`+0x600. `exc_event` is unchanged.
- R11: All outputs update on the clock edge where `accept` is high. `done` is high for exactly the following cycle. Without `accept`, nothing changes and `done` stays low.
- R12: Synchronous reset clears every registered output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept | input | 1 | One-cycle strobe: the core takes the pending event now |
| exc_valid | input | 1 | An exception code is pending |
| exc_code | input | CODE_W | Pending exception code |
| irq_req | input | 1 | An interrupt request is pending |
| sleep_in | input | 1 | Core is in the sleep state |
| ds_in | input | 1 | Current instruction sits in a branch delay slot |
| sr_in | input | XLEN | Current status word |
| pc_in | input | XLEN | Current program counter |
| vbr_in | input | XLEN | Vector base |
| r15_in | input | XLEN | Current stack register |
| imask | output | MASK_W | Interrupt mask handed to the interrupt controller |
| ic_vec_valid | input | 1 | Controller returned a vector |
| ic_vec | input | CODE_W | Vector returned by the controller |
| done | output | 1 | Entry completed on the previous edge |
| sleep_clr | output | 1 | Pulse: leave the sleep state |
| ds_clr | output | 1 | Pulse: drop the delay-slot flags |
| sr_out | output | XLEN | New status word |
| pc_out | output | XLEN | Handler address |
| saved_sr | output | XLEN | Shadow copy of the status word |
| saved_pc | output | XLEN | Shadow copy of the adjusted PC |
| saved_r15 | output | XLEN | Shadow copy of the stack register |
| exc_event | output | CODE_W | Last exception code handled |
| int_event | output | CODE_W | Last interrupt vector handled |

## Verification
The bench builds the block with its defaults: 32-bit data, 12-bit codes, the mask in bits 7:4, the mode bits at 28 to 30 and the fixed reset address 0xA0000000. With these values the literal handler addresses and status words can be written straight into the vector table. The table covers every vector class, the block-bit conversion (including the 0x1E0 exception and the lost trap adjustment), and the sleep-gated and vector-less interrupts. The table also places delay slots on both an exception and an interrupt.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_EXC  = 2'd1,
    TAKE_IRQ  = 2'd2
  } take_e;

  localparam int EC_POWER    = 'h000;
  localparam int EC_MANUAL   = 'h020;
  localparam int EC_MULTIHIT = 'h140;
  localparam int EC_MISS_RD  = 'h040;
  localparam int EC_MISS_WR  = 'h060;
  localparam int EC_TRAP     = 'h160;
  localparam int EC_UNMASKED = 'h1E0;
endpackage

// File: rtl/exc_entry_arbiter.sv
module exc_entry_arbiter
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              accept,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              sleep_in,
  input  logic              blk_in,
  input  logic              ic_vec_valid,
  output take_e             take,
  output logic [CODE_W-1:0] eff_code
);
  logic irq_open;

  // block bit forces a masked exception into the power-on code
  always_comb begin
    eff_code = exc_code;
    if (blk_in && exc_code != CODE_W'(EC_UNMASKED))
      eff_code = CODE_W'(EC_POWER);
  end

  assign irq_open = irq_req && !exc_valid && (!blk_in || sleep_in) && ic_vec_valid;

  always_comb begin
    take = TAKE_NONE;
    if (accept) begin
      if (exc_valid)     take = TAKE_EXC;
      else if (irq_open) take = TAKE_IRQ;
    end
  end
endmodule

// File: rtl/exc_entry_vector.sv
module exc_entry_vector
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          CODE_W     = 12,
  parameter int          MASK_LSB   = 4,
  parameter int          MASK_W     = 4,
  parameter int          BLK_BIT    = 28,
  parameter int          BANK_BIT   = 29,
  parameter int          PRIV_BIT   = 30,
  parameter int          FPD_BIT    = 15,
  parameter int          INSN_BYTES = 2,
  parameter int          OFS_GEN    = 'h100,
  parameter int          OFS_TLB    = 'h400,
  parameter int          OFS_IRQ    = 'h600,
  parameter logic [XLEN-1:0] RESET_PC = 'hA000_0000
) (
  input  take_e             take,
  input  logic [CODE_W-1:0] eff_code,
  input  logic [CODE_W-1:0] ic_vec,
  input  logic              ds_in,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   vbr_in,
  output logic [XLEN-1:0]   nxt_sr,
  output logic [XLEN-1:0]   nxt_pc,
  output logic [XLEN-1:0]   nxt_spc,
  output logic [CODE_W-1:0] nxt_evt
);
  localparam logic [XLEN-1:0] ENTRY_SET =
    (XLEN'(1) << BLK_BIT) | (XLEN'(1) << BANK_BIT) | (XLEN'(1) << PRIV_BIT);

  logic is_exc, is_irq, rst_class, tlb_class, is_trap;

  assign is_exc    = (take == TAKE_EXC);
  assign is_irq    = (take == TAKE_IRQ);
  assign rst_class = eff_code == CODE_W'(EC_POWER) || eff_code == CODE_W'(EC_MANUAL) ||
                     eff_code == CODE_W'(EC_MULTIHIT);
  assign tlb_class = eff_code == CODE_W'(EC_MISS_RD) || eff_code == CODE_W'(EC_MISS_WR);
  assign is_trap   = eff_code == CODE_W'(EC_TRAP);

  always_comb begin
    nxt_sr = sr_in | ENTRY_SET;
    if (is_exc && rst_class) begin
      nxt_sr[FPD_BIT]                = 1'b0;
      nxt_sr[MASK_LSB +: MASK_W]     = '1;
    end
  end

  always_comb begin
    nxt_spc = pc_in;
    if (ds_in)            nxt_spc = nxt_spc - XLEN'(INSN_BYTES);
    if (is_exc && is_trap) nxt_spc = nxt_spc + XLEN'(INSN_BYTES);
  end

  always_comb begin
    if (is_irq)         nxt_pc = vbr_in + XLEN'(OFS_IRQ);
    else if (rst_class) nxt_pc = RESET_PC;
    else if (tlb_class) nxt_pc = vbr_in + XLEN'(OFS_TLB);
    else                nxt_pc = vbr_in + XLEN'(OFS_GEN);
  end

  assign nxt_evt = is_irq ? ic_vec : eff_code;
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  take_e             take,
  input  logic              ds_in,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   nxt_sr,
  input  logic [XLEN-1:0]   nxt_pc,
  input  logic [XLEN-1:0]   nxt_spc,
  input  logic [CODE_W-1:0] nxt_evt,
  output logic              done,
  output logic              sleep_clr,
  output logic              ds_clr,
  output logic [XLEN-1:0]   sr_out,
  output logic [XLEN-1:0]   pc_out,
  output logic [XLEN-1:0]   saved_sr,
  output logic [XLEN-1:0]   saved_pc,
  output logic [XLEN-1:0]   saved_r15,
  output logic [CODE_W-1:0] exc_event,
  output logic [CODE_W-1:0] int_event
);
  logic proceed;
  assign proceed = (take != TAKE_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      sleep_clr <= 1'b0;
      ds_clr    <= 1'b0;
      sr_out    <= '0;
      pc_out    <= '0;
      saved_sr  <= '0;
      saved_pc  <= '0;
      saved_r15 <= '0;
      exc_event <= '0;
      int_event <= '0;
    end else begin
      done      <= proceed;
      sleep_clr <= proceed;
      ds_clr    <= proceed && ds_in;
      if (proceed) begin
        saved_sr  <= sr_in;
        saved_pc  <= nxt_spc;
        saved_r15 <= r15_in;
        sr_out    <= nxt_sr;
        pc_out    <= nxt_pc;
      end
      if (take == TAKE_EXC) exc_event <= nxt_evt;
      if (take == TAKE_IRQ) int_event <= nxt_evt;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CODE_W   = 12,
  parameter int MASK_LSB = 4,
  parameter int MASK_W   = 4,
  parameter int BLK_BIT  = 28,
  parameter int BANK_BIT = 29,
  parameter int PRIV_BIT = 30,
  parameter int FPD_BIT  = 15,
  parameter int OFS_IRQ  = 'h600,
  parameter logic [XLEN-1:0] RESET_PC = 'hA000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              sleep_in,
  input  logic              ds_in,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic [XLEN-1:0]   r15_in,
  output logic [MASK_W-1:0] imask,
  input  logic              ic_vec_valid,
  input  logic [CODE_W-1:0] ic_vec,
  output logic              done,
  output logic              sleep_clr,
  output logic              ds_clr,
  output logic [XLEN-1:0]   sr_out,
  output logic [XLEN-1:0]   pc_out,
  output logic [XLEN-1:0]   saved_sr,
  output logic [XLEN-1:0]   saved_pc,
  output logic [XLEN-1:0]   saved_r15,
  output logic [CODE_W-1:0] exc_event,
  output logic [CODE_W-1:0] int_event
);
  take_e             take;
  logic [CODE_W-1:0] eff_code, nxt_evt;
  logic [XLEN-1:0]   nxt_sr, nxt_pc, nxt_spc;

  assign imask = sr_in[MASK_LSB +: MASK_W];

  exc_entry_arbiter #(.CODE_W(CODE_W)) u_arb (
    .accept(accept), .exc_valid(exc_valid), .exc_code(exc_code),
    .irq_req(irq_req), .sleep_in(sleep_in), .blk_in(sr_in[BLK_BIT]),
    .ic_vec_valid(ic_vec_valid), .take(take), .eff_code(eff_code)
  );

  exc_entry_vector #(
    .XLEN(XLEN), .CODE_W(CODE_W), .MASK_LSB(MASK_LSB), .MASK_W(MASK_W),
    .BLK_BIT(BLK_BIT), .BANK_BIT(BANK_BIT), .PRIV_BIT(PRIV_BIT), .FPD_BIT(FPD_BIT),
    .OFS_IRQ(OFS_IRQ), .RESET_PC(RESET_PC)
  ) u_vec (
    .take(take), .eff_code(eff_code), .ic_vec(ic_vec), .ds_in(ds_in),
    .sr_in(sr_in), .pc_in(pc_in), .vbr_in(vbr_in),
    .nxt_sr(nxt_sr), .nxt_pc(nxt_pc), .nxt_spc(nxt_spc), .nxt_evt(nxt_evt)
  );

  exc_entry_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .take(take), .ds_in(ds_in), .sr_in(sr_in), .r15_in(r15_in),
    .nxt_sr(nxt_sr), .nxt_pc(nxt_pc), .nxt_spc(nxt_spc), .nxt_evt(nxt_evt),
    .done(done), .sleep_clr(sleep_clr), .ds_clr(ds_clr), .sr_out(sr_out),
    .pc_out(pc_out), .saved_sr(saved_sr), .saved_pc(saved_pc), .saved_r15(saved_r15),
    .exc_event(exc_event), .int_event(int_event)
  );

  // R1: exception entry completes and leaves the interrupt record alone
  a_r1_exc_wins: assert property (@(posedge clk) disable iff (rst)
    accept && exc_valid |=> done && $stable(int_event));

  // R2: masked exception lands on the reset address with code zero
  a_r2_masked_to_reset: assert property (@(posedge clk) disable iff (rst)
    accept && exc_valid && sr_in[BLK_BIT] && exc_code != CODE_W'(EC_UNMASKED)
    |=> exc_event == '0 && pc_out == RESET_PC);

  // R3: blocked interrupt outside sleep changes nothing
  a_r3_blocked_irq: assert property (@(posedge clk) disable iff (rst)
    accept && !exc_valid && sr_in[BLK_BIT] && !sleep_in
    |=> !done && $stable(pc_out) && $stable(int_event));

  // R4: no vector from the controller means no entry
  a_r4_no_vector: assert property (@(posedge clk) disable iff (rst)
    accept && !exc_valid && !ic_vec_valid |=> !done && $stable(saved_pc));

  // R5: shadow copies hold the context of the accept cycle
  a_r5_shadow: assert property (@(posedge clk) disable iff (rst)
    done |-> saved_r15 == $past(r15_in) && saved_sr == $past(sr_in) &&
             sr_out[BLK_BIT] && sr_out[PRIV_BIT] && sr_out[BANK_BIT]);

  // R10: accepted interrupt takes the controller vector and the interrupt slot
  a_r10_irq_entry: assert property (@(posedge clk) disable iff (rst)
    accept && !exc_valid && irq_req && ic_vec_valid && (!sr_in[BLK_BIT] || sleep_in)
    |=> done && int_event == $past(ic_vec) && pc_out == $past(vbr_in) + XLEN'(OFS_IRQ));

  // R11: no accept, no done
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !done && $stable(pc_out));
endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
  typedef struct packed {
    logic        ev;
    logic [11:0] code;
    logic        irq;
    logic        slp;
    logic        ds;
    logic        icv;
    logic [11:0] icvec;
    logic [31:0] sr;
    logic        e_done;
    logic [31:0] e_pc;
    logic [31:0] e_spc;
    logic [31:0] e_sr;
    logic [11:0] e_evt;
  } vec_t;

  function automatic vec_t mk(logic ev, logic [11:0] code, logic irq, logic slp,
                              logic ds, logic icv, logic [11:0] icvec, logic [31:0] sr,
                              logic e_done, logic [31:0] e_pc, logic [31:0] e_spc,
                              logic [31:0] e_sr, logic [11:0] e_evt);
    mk = {ev, code, irq, slp, ds, icv, icvec, sr, e_done, e_pc, e_spc, e_sr, e_evt};
  endfunction

  localparam logic [31:0] SR0 = 32'h0000_8030;
  localparam logic [31:0] SRB = 32'h1000_8030;
  localparam logic [31:0] PC  = 32'h0C00_1000;
  localparam logic [31:0] VBR = 32'h0C00_0000;
  localparam int NV = 16;

  localparam vec_t TBL [NV] = '{
    mk(1, 12'h040, 0, 0, 0, 0, 12'h000, SR0, 1, 32'h0C000400, 32'h0C001000, 32'h70008030, 12'h040),
    mk(1, 12'h060, 1, 0, 1, 1, 12'h320, SR0, 1, 32'h0C000400, 32'h0C000FFE, 32'h70008030, 12'h060),
    mk(1, 12'h180, 0, 0, 0, 0, 12'h000, SR0, 1, 32'h0C000100, 32'h0C001000, 32'h70008030, 12'h180),
    mk(1, 12'h160, 0, 0, 0, 0, 12'h000, SR0, 1, 32'h0C000100, 32'h0C001002, 32'h70008030, 12'h160),
    mk(1, 12'h160, 0, 0, 1, 0, 12'h000, SR0, 1, 32'h0C000100, 32'h0C001000, 32'h70008030, 12'h160),
    mk(1, 12'h020, 0, 0, 0, 0, 12'h000, SR0, 1, 32'hA0000000, 32'h0C001000, 32'h700000F0, 12'h020),
    mk(1, 12'h140, 0, 0, 0, 0, 12'h000, SR0, 1, 32'hA0000000, 32'h0C001000, 32'h700000F0, 12'h140),
    mk(1, 12'h000, 0, 0, 0, 0, 12'h000, SR0, 1, 32'hA0000000, 32'h0C001000, 32'h700000F0, 12'h000),
    mk(1, 12'h0A0, 0, 0, 0, 0, 12'h000, SRB, 1, 32'hA0000000, 32'h0C001000, 32'h700000F0, 12'h000),
    mk(1, 12'h1E0, 0, 0, 0, 0, 12'h000, SRB, 1, 32'h0C000100, 32'h0C001000, 32'h70008030, 12'h1E0),
    mk(1, 12'h160, 0, 0, 0, 0, 12'h000, SRB, 1, 32'hA0000000, 32'h0C001000, 32'h700000F0, 12'h000),
    mk(0, 12'h000, 1, 0, 0, 1, 12'h320, SR0, 1, 32'h0C000600, 32'h0C001000, 32'h70008030, 12'h320),
    mk(0, 12'h000, 1, 0, 0, 1, 12'h3C0, SRB, 0, 32'h0C000600, 32'h0C001000, 32'h70008030, 12'h320),
    mk(0, 12'h000, 1, 1, 0, 1, 12'h3A0, SRB, 1, 32'h0C000600, 32'h0C001000, 32'h70008030, 12'h3A0),
    mk(0, 12'h000, 1, 0, 0, 0, 12'h000, SR0, 0, 32'h0C000600, 32'h0C001000, 32'h70008030, 12'h3A0),
    mk(0, 12'h000, 1, 0, 1, 1, 12'h200, SR0, 1, 32'h0C000600, 32'h0C000FFE, 32'h70008030, 12'h200)
  };

  function automatic string tag(int i);
    case (i)
      0, 2:        tag = "R8";
      1:           tag = "R1";
      3, 4:        tag = "R9";
      5, 6, 7:     tag = "R7";
      8, 9, 10:    tag = "R2";
      11:          tag = "R10";
      12, 13:      tag = "R3";
      14:          tag = "R4";
      default:     tag = "R6";
    endcase
  endfunction

  logic clk = 1'b0, rst = 1'b1, accept = 1'b0, exc_valid = 1'b0, irq_req = 1'b0;
  logic sleep_in = 1'b0, ds_in = 1'b0, ic_vec_valid = 1'b0;
  logic [11:0] exc_code = '0, ic_vec = '0;
  logic [31:0] sr_in = '0, pc_in = '0, vbr_in = '0, r15_in = '0;
  logic [3:0]  imask;
  logic        done, sleep_clr, ds_clr;
  logic [31:0] sr_out, pc_out, saved_sr, saved_pc, saved_r15;
  logic [11:0] exc_event, int_event;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst(rst), .accept(accept), .exc_valid(exc_valid), .exc_code(exc_code),
    .irq_req(irq_req), .sleep_in(sleep_in), .ds_in(ds_in), .sr_in(sr_in), .pc_in(pc_in),
    .vbr_in(vbr_in), .r15_in(r15_in), .imask(imask), .ic_vec_valid(ic_vec_valid),
    .ic_vec(ic_vec), .done(done), .sleep_clr(sleep_clr), .ds_clr(ds_clr),
    .sr_out(sr_out), .pc_out(pc_out), .saved_sr(saved_sr), .saved_pc(saved_pc),
    .saved_r15(saved_r15), .exc_event(exc_event), .int_event(int_event)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_zero(string req);
    chk(req, "done", {31'd0, done}, 32'd0);
    chk(req, "sleep_clr", {31'd0, sleep_clr}, 32'd0);
    chk(req, "ds_clr", {31'd0, ds_clr}, 32'd0);
    chk(req, "sr_out", sr_out, 32'd0);
    chk(req, "pc_out", pc_out, 32'd0);
    chk(req, "saved_sr", saved_sr, 32'd0);
    chk(req, "saved_pc", saved_pc, 32'd0);
    chk(req, "saved_r15", saved_r15, 32'd0);
    chk(req, "exc_event", {20'd0, exc_event}, 32'd0);
    chk(req, "int_event", {20'd0, int_event}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_sr, last_r15;
    last_sr = '0;
    last_r15 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_zero("R12");

    pc_in = PC;
    vbr_in = VBR;
    for (int i = 0; i < NV; i++) begin
      exc_valid    = TBL[i].ev;
      exc_code     = TBL[i].code;
      irq_req      = TBL[i].irq;
      sleep_in     = TBL[i].slp;
      ds_in        = TBL[i].ds;
      ic_vec_valid = TBL[i].icv;
      ic_vec       = TBL[i].icvec;
      sr_in        = TBL[i].sr;
      r15_in       = 32'h0D00_0000 + 32'(i);
      accept       = 1'b1;
      #1;
      chk("R4", "imask", {28'd0, imask}, {28'd0, TBL[i].sr[7:4]});
      @(negedge clk);
      accept = 1'b0;
      if (TBL[i].e_done) begin
        last_sr  = TBL[i].sr;
        last_r15 = r15_in;
      end
      chk(tag(i), "done", {31'd0, done}, {31'd0, TBL[i].e_done});
      chk(tag(i), "R3 sleep_clr", {31'd0, sleep_clr}, {31'd0, TBL[i].e_done});
      chk(tag(i), "R6 ds_clr", {31'd0, ds_clr}, {31'd0, TBL[i].e_done & TBL[i].ds});
      chk(tag(i), "pc_out", pc_out, TBL[i].e_pc);
      chk(tag(i), "saved_pc", saved_pc, TBL[i].e_spc);
      chk(tag(i), "sr_out", sr_out, TBL[i].e_sr);
      chk(tag(i), "R5 saved_sr", saved_sr, last_sr);
      chk(tag(i), "R5 saved_r15", saved_r15, last_r15);
      if (TBL[i].ev) chk(tag(i), "exc_event", {20'd0, exc_event}, {20'd0, TBL[i].e_evt});
      else           chk(tag(i), "int_event", {20'd0, int_event}, {20'd0, TBL[i].e_evt});
      if (!TBL[i].ev) chk("R10", "exc_event kept", {20'd0, exc_event}, 32'd0);
    end

    // R11: pending exception without accept changes nothing
    exc_valid = 1'b1; exc_code = 12'h180; sr_in = SR0; ds_in = 1'b0;
    irq_req = 1'b0; sleep_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "done idle", {31'd0, done}, 32'd0);
    chk("R11", "pc_out idle", pc_out, 32'h0C000600);
    chk("R11", "exc_event idle", {20'd0, exc_event}, 32'd0);

    // R1: exception and interrupt together: interrupt record untouched
    irq_req = 1'b1; ic_vec_valid = 1'b1; ic_vec = 12'h111; accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    chk("R1", "exc_event", {20'd0, exc_event}, 32'h180);
    chk("R1", "int_event kept", {20'd0, int_event}, 32'h200);
    chk("R8", "pc_out general", pc_out, 32'h0C000100);
    @(negedge clk);
    chk("R11", "done single pulse", {31'd0, done}, 32'd0);

    // R4: mask follows the status word
    sr_in = 32'h0000_00A0;
    #1;
    chk("R4", "imask A", {28'd0, imask}, 32'hA);

    // R12: reset in mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exc_valid = 1'b0; irq_req = 1'b0;
    @(negedge clk);
    check_zero("R12");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule